// File: doc/BRIEF.md
# Angular Separation Bin Classifier

This block takes a pair of unit vectors, each given as three signed fixed-point coordinates, and decides which histogram bin their angular separation falls into. It forms the exact dot product of the two vectors. It then places that value among a programmable table of bin edges, which are stored as cosines. Small angles have cosines close to 1.0, so the useful edges sit just below 1.0 and a wide fixed-point fraction keeps them distinct. Floating point is not used anywhere.

The edge table has 2^LEVELS - 1 entries, 31 by default. Together they define 2^LEVELS bins. Software fills the table before a run by presenting one edge per load strobe, with the largest edge (smallest angle) first. The table must be non-increasing from position 0 onward.

During a run the block accepts one vector pair on every clock in which `in_valid` is high. Each accepted pair yields one bin index with `out_valid`, after a fixed delay. The search is a balanced binary tree of strict less-than tests, and every level of the tree is a pipeline register. Converting angles to cosines, fetching coordinates and accumulating the histogram are left to neighbouring logic.

Top module: `angsep_bin_classifier`

## Requirements
- R1: The value classified is the exact signed sum ax*bx + ay*by + az*bz. It is computed at full width without rounding or overflow: the products are 2*COORD_W bits wide and the sum is 2*COORD_W+2 bits wide.
- R2: A dot product greater than or equal to edge position 0 gives bin index 0.
- R3: For 1 <= i <= 2^LEVELS-2, the index is i exactly when edge i-1 is greater than the dot product and the dot product is greater than or equal to edge i. A dot product equal to edge i therefore gives index i.
- R4: A dot product below the last edge (position 2^LEVELS-2) gives the highest index, 2^LEVELS-1 (31 by default).
- R5: Each cycle with `ld_strobe` high shifts `ld_value` into the last edge position, and every stored edge moves one position toward 0. After 2^LEVELS-1 strobes, the first value loaded holds position 0 and the last value loaded holds the last position.
- R6: A pair presented with `in_valid` high produces its index with `out_valid` high exactly LEVELS+2 clock edges later (7 by default). Pairs presented on consecutive cycles produce results on consecutive cycles, in the order they were presented.
- R7: A cycle with `in_valid` low produces no result, whatever the coordinate inputs carry, and it does not disturb the results of pairs on either side of it.
- R8: After a synchronous reset (`rst` high at a clock edge), `out_valid` is low and every stored edge is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_strobe | input | 1 | Shifts `ld_value` into the edge table |
| ld_value | input | 2*COORD_W+2 | Edge value, signed, in dot-product format |
| in_valid | input | 1 | A vector pair is present this cycle |
| ax | input | COORD_W | First vector x, signed fixed point |
| ay | input | COORD_W | First vector y, signed fixed point |
| az | input | COORD_W | First vector z, signed fixed point |
| bx | input | COORD_W | Second vector x, signed fixed point |
| by | input | COORD_W | Second vector y, signed fixed point |
| bz | input | COORD_W | Second vector z, signed fixed point |
| out_valid | output | 1 | A bin index is present this cycle |
| out_bin | output | LEVELS | Bin index, 0 for the smallest angles |

## Verification
A wrong product or a lost carry in the sum shows up at the ports as a bin index off by one or more, seven edges after the faulty pair. A mis-selected edge inside the tree has the same effect, but only for dot products near the affected edge. To catch this, the sweeps drive dot products that land exactly on every edge and one step below it. A mis-ordered edge chain moves every bin boundary at once, and a slip in the valid pipeline adds or drops a result or shifts its arrival cycle. Both are visible on the first pair after the table load.

// File: rtl/angsep_pkg.sv
package angsep_pkg;

    // Edge position tested at tree level `stage` once the upper `stage`
    // index bits (prefix) are known.
    function automatic int node_of(input int prefix, input int stage, input int levels);
        return (prefix << (levels - stage)) + (1 << (levels - stage - 1)) - 1;
    endfunction

endpackage

// File: rtl/angsep_bound_chain.sv
module angsep_bound_chain #(
    parameter int W = 88,
    parameter int N = 31
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ld_strobe,
    input  logic signed [W-1:0] ld_value,
    output logic signed [W-1:0] bnd [N]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) bnd[i] <= '0;
        end else if (ld_strobe) begin
            for (int i = 0; i < N - 1; i++) bnd[i] <= bnd[i+1];
            bnd[N-1] <= ld_value;
        end
    end

endmodule

// File: rtl/angsep_dot_pipe.sv
module angsep_dot_pipe #(
    parameter int COORD_W = 43,
    localparam int PW = 2 * COORD_W,
    localparam int DOT_W = PW + 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic signed [COORD_W-1:0] ax,
    input  logic signed [COORD_W-1:0] ay,
    input  logic signed [COORD_W-1:0] az,
    input  logic signed [COORD_W-1:0] bx,
    input  logic signed [COORD_W-1:0] by,
    input  logic signed [COORD_W-1:0] bz,
    output logic                      dot_vld,
    output logic signed [DOT_W-1:0]   dot_q
);

    logic signed [PW-1:0] p_x, p_y, p_z;
    logic                 prod_vld;

    // multiply stage
    always_ff @(posedge clk) begin
        if (rst) prod_vld <= 1'b0;
        else     prod_vld <= in_valid;
        p_x <= ax * bx;
        p_y <= ay * by;
        p_z <= az * bz;
    end

    // add stage, sign extended to full width
    always_ff @(posedge clk) begin
        if (rst) dot_vld <= 1'b0;
        else     dot_vld <= prod_vld;
        dot_q <= {{2{p_x[PW-1]}}, p_x} + {{2{p_y[PW-1]}}, p_y} + {{2{p_z[PW-1]}}, p_z};
    end

endmodule

// File: rtl/angsep_cmp_tree.sv
module angsep_cmp_tree #(
    parameter int W = 88,
    parameter int LEVELS = 5,
    localparam int NB = (1 << LEVELS) - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_dot,
    input  logic signed [W-1:0] bnd [NB],
    output logic                out_vld,
    output logic [LEVELS-1:0]   out_idx
);

    // registered outputs of each tree level
    logic                q_vld [LEVELS];
    logic signed [W-1:0] q_dot [LEVELS];
    logic [LEVELS-1:0]   q_idx [LEVELS];

    // inputs of each tree level
    logic                c_vld [LEVELS];
    logic signed [W-1:0] c_dot [LEVELS];
    logic [LEVELS-1:0]   c_idx [LEVELS];
    logic [LEVELS-1:0]   c_sel [LEVELS];
    logic                c_go  [LEVELS];

    always_comb begin
        for (int s = 0; s < LEVELS; s++) begin
            if (s == 0) begin
                c_vld[s] = in_vld;
                c_dot[s] = in_dot;
                c_idx[s] = '0;
            end else begin
                c_vld[s] = q_vld[s-1];
                c_dot[s] = q_dot[s-1];
                c_idx[s] = q_idx[s-1];
            end
            c_sel[s] = LEVELS'(angsep_pkg::node_of(int'(c_idx[s]), s, LEVELS));
            c_go[s]  = c_dot[s] < bnd[c_sel[s]];
        end
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < LEVELS; s++) begin
            if (rst) q_vld[s] <= 1'b0;
            else     q_vld[s] <= c_vld[s];
            q_dot[s] <= c_dot[s];
            q_idx[s] <= {c_idx[s][LEVELS-2:0], c_go[s]};
        end
    end

    assign out_vld = q_vld[LEVELS-1];
    assign out_idx = q_idx[LEVELS-1];

endmodule

// File: rtl/angsep_bin_classifier.sv
module angsep_bin_classifier #(
    parameter int COORD_W = 43,
    parameter int LEVELS = 5,
    localparam int DOT_W = 2 * COORD_W + 2,
    localparam int NB = (1 << LEVELS) - 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_strobe,
    input  logic signed [DOT_W-1:0]   ld_value,
    input  logic                      in_valid,
    input  logic signed [COORD_W-1:0] ax,
    input  logic signed [COORD_W-1:0] ay,
    input  logic signed [COORD_W-1:0] az,
    input  logic signed [COORD_W-1:0] bx,
    input  logic signed [COORD_W-1:0] by,
    input  logic signed [COORD_W-1:0] bz,
    output logic                      out_valid,
    output logic [LEVELS-1:0]         out_bin
);

    logic signed [DOT_W-1:0] bnd [NB];
    logic signed [DOT_W-1:0] dot_q;
    logic                    dot_vld;

    angsep_bound_chain #(.W(DOT_W), .N(NB)) u_chain (
        .clk(clk), .rst(rst), .ld_strobe(ld_strobe), .ld_value(ld_value), .bnd(bnd)
    );

    angsep_dot_pipe #(.COORD_W(COORD_W)) u_dot (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .ax(ax), .ay(ay), .az(az), .bx(bx), .by(by), .bz(bz),
        .dot_vld(dot_vld), .dot_q(dot_q)
    );

    angsep_cmp_tree #(.W(DOT_W), .LEVELS(LEVELS)) u_tree (
        .clk(clk), .rst(rst), .in_vld(dot_vld), .in_dot(dot_q), .bnd(bnd),
        .out_vld(out_valid), .out_idx(out_bin)
    );

endmodule

// File: rtl/angsep_bin_classifier_chk.sv
module angsep_bin_classifier_chk #(
    parameter int COORD_W = 43,
    parameter int LEVELS = 5,
    localparam int DOT_W = 2 * COORD_W + 2,
    localparam int NB = (1 << LEVELS) - 1,
    localparam int LAT = LEVELS + 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      ld_strobe,
    input logic                      in_valid,
    input logic signed [COORD_W-1:0] ax,
    input logic signed [COORD_W-1:0] ay,
    input logic signed [COORD_W-1:0] az,
    input logic signed [COORD_W-1:0] bx,
    input logic signed [COORD_W-1:0] by,
    input logic signed [COORD_W-1:0] bz,
    input logic                      dot_vld,
    input logic signed [DOT_W-1:0]   dot_q,
    input logic signed [DOT_W-1:0]   bnd [NB],
    input logic                      out_valid,
    input logic [LEVELS-1:0]         out_bin
);

    logic [LAT-1:0]          vld_hist;
    logic signed [DOT_W-1:0] d_hist [LEVELS];
    int                      quiet;
    logic signed [DOT_W-1:0] ref_dot, d_out, lo_b, hi_b;
    logic                    tab_ok;

    always_comb begin
        ref_dot = DOT_W'(ax * bx) + DOT_W'(ay * by) + DOT_W'(az * bz);
        d_out   = d_hist[LEVELS-1];
        lo_b    = (int'(out_bin) < NB) ? bnd[out_bin] : bnd[0];
        hi_b    = (out_bin != '0) ? bnd[out_bin - 1'b1] : bnd[0];
        tab_ok  = quiet > LAT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_hist <= '0;
            quiet    <= 0;
        end else begin
            vld_hist <= {vld_hist[LAT-2:0], in_valid};
            if (ld_strobe)         quiet <= 0;
            else if (quiet <= LAT) quiet <= quiet + 1;
        end
        d_hist[0] <= dot_q;
        for (int k = 1; k < LEVELS; k++) d_hist[k] <= d_hist[k-1];
    end

    // R1: sum stage carries the exact dot product of the pair two edges back
    a_r1_dot_exact: assert property (@(posedge clk) disable iff (rst)
        dot_vld |-> dot_q == $past(ref_dot, 2));

    // R6 / R7: a result appears exactly when a pair was accepted LAT edges earlier
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        out_valid == vld_hist[LAT-1]);

    a_r2_top_bin: assert property (@(posedge clk) disable iff (rst)
        (out_valid && tab_ok && d_out >= bnd[0]) |-> out_bin == '0);

    a_r4_bottom_bin: assert property (@(posedge clk) disable iff (rst)
        (out_valid && tab_ok && d_out < bnd[NB-1]) |-> int'(out_bin) == NB);

    a_r3_between: assert property (@(posedge clk) disable iff (rst)
        (out_valid && tab_ok && out_bin != '0 && int'(out_bin) != NB)
        |-> (hi_b > d_out && d_out >= lo_b));

endmodule

bind angsep_bin_classifier angsep_bin_classifier_chk #(.COORD_W(COORD_W), .LEVELS(LEVELS)) u_chk (
    .clk(clk), .rst(rst), .ld_strobe(ld_strobe), .in_valid(in_valid),
    .ax(ax), .ay(ay), .az(az), .bx(bx), .by(by), .bz(bz),
    .dot_vld(dot_vld), .dot_q(dot_q), .bnd(bnd),
    .out_valid(out_valid), .out_bin(out_bin)
);

// File: tb/angsep_bin_classifier_bench.sv
module angsep_bin_classifier_bench;

    localparam int CW = 8;
    localparam int LV = 5;
    localparam int DW = 2 * CW + 2;
    localparam int NB = (1 << LV) - 1;
    localparam int LAT = LV + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_strobe = 1'b0;
    logic signed [DW-1:0] ld_value = '0;
    logic in_valid = 1'b0;
    logic signed [CW-1:0] ax = '0, ay = '0, az = '0, bx = '0, by = '0, bz = '0;
    logic out_valid;
    logic [LV-1:0] out_bin;

    angsep_bin_classifier #(.COORD_W(CW), .LEVELS(LV)) u_angsep_bin_classifier (
        .clk(clk), .rst(rst), .ld_strobe(ld_strobe), .ld_value(ld_value),
        .in_valid(in_valid), .ax(ax), .ay(ay), .az(az), .bx(bx), .by(by), .bz(bz),
        .out_valid(out_valid), .out_bin(out_bin)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tx = 0;
    int rx = 0;
    bit done = 0;
    int bm [NB];
    int exp_bin [16384];
    int exp_cyc [16384];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // linear search over the table as loaded (first value at position 0)
    function automatic int model(input int d);
        if (d >= bm[0]) return 0;
        for (int i = 1; i < NB; i++) if (d >= bm[i]) return i;
        return NB;
    endfunction

    task automatic load_table(input int base, input int step);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            ld_strobe = 1'b1;
            ld_value  = DW'(base - step * i);
            bm[i]     = base - step * i;
        end
        @(negedge clk);
        ld_strobe = 1'b0;
    endtask

    task automatic send(input int a1, input int b1, input int c1,
                        input int a2, input int b2, input int c2);
        @(negedge clk);
        in_valid = 1'b1;
        ax = CW'(a1); ay = CW'(b1); az = CW'(c1);
        bx = CW'(a2); by = CW'(b2); bz = CW'(c2);
        exp_bin[tx] = model(a1 * a2 + b1 * b2 + c1 * c2);
        exp_cyc[tx] = cyc + LAT;
        tx++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            ax = 8'sd127; bx = 8'sd127; ay = -8'sd128; by = 8'sd5; az = 8'sd3; bz = -8'sd9;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rx >= tx) begin
                check(1'b0, "R7 unexpected result", int'(out_bin), -1);
            end else begin
                if (exp_bin[rx] == 0)
                    check(int'(out_bin) == 0, "R2/R1/R5 bin", int'(out_bin), exp_bin[rx]);
                else if (exp_bin[rx] == NB)
                    check(int'(out_bin) == NB, "R4/R1/R5 bin", int'(out_bin), exp_bin[rx]);
                else
                    check(int'(out_bin) == exp_bin[rx], "R3/R1/R5 bin", int'(out_bin), exp_bin[rx]);
                check(cyc == exp_cyc[rx], "R6 latency", cyc, exp_cyc[rx]);
            end
            rx++;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid after reset", int'(out_valid), 0);

        // R8: cleared table is all zero, so dot 0 -> bin 0 and dot -1 -> top bin
        for (int i = 0; i < NB; i++) bm[i] = 0;
        send(0, 0, 0, 0, 0, 0);
        send(1, 0, 0, -1, 0, 0);
        idle(LAT + 2);

        // Table 1: wide spacing, back-to-back 3-D sweep (R1 R3 R6)
        load_table(12000, 800);
        for (int a = -128; a < 128; a += 3)
            for (int b = -128; b < 128; b += 5)
                send(a, (a * 7) % 128, (b * 3) % 100, b, (b * 11) % 128, (a * 5) % 90);
        // exact hits on edges 0, 15 and 30 and just below (R2 R3 R4)
        send(100, 0, 0, 120, 0, 0);
        send(0, 0, 0, 0, 0, 0);
        send(1, 0, 0, -1, 0, 0);
        send(-100, 0, 0, 120, 0, 0);
        send(-100, 1, 0, 120, -1, 0);
        send(127, 127, 127, 127, 127, 127);
        send(-128, -128, -128, 127, 127, 127);
        idle(LAT + 2);

        // Table 2: unit spacing line sweep hitting every edge and one step below,
        // with gaps of invalid cycles carrying junk inputs (R7)
        load_table(120, 8);
        for (int a = -128; a < 128; a++) begin
            send(a, 0, 0, 1, 0, 0);
            if ((a & 3) == 0) idle(2);
            send(0, a, 0, 0, -1, 0);
        end
        idle(LAT + 4);

        check(rx == tx, "R7 result count", rx, tx);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", rx, tx);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule